// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave

This block is the target side of a two-wire, SMBus-compatible serial bus. It serves a small bank of 16-bit registers through an 8-bit pointer. A bus master first writes the pointer, optionally followed by one data word. The master can then read the word at that pointer as many times as it needs without sending the pointer again. Two of the registers are live measurement inputs. One is a configuration word held in the block. Two are fixed identity constants.

SCL and SDA arrive as raw samples of the bus and are synchronized inside the block. SDA is driven open-drain through a single pull-down enable. The two address-select inputs are sampled afresh at every START. The first of them is a plain level. The second arrives already resolved into a 2-bit code that tells low, high, tied-to-data and tied-to-clock apart. A high-speed master code is recognised without an acknowledge, and it raises a filter-mode flag for external input filters.

Top module: `tws_sensor_slave`

## Requirements
- R1: The 7-bit target address is binary 1000 followed by the select bit `adrSel1` and then the 2-bit code `adrSel0Code` (00 low, 01 high, 10 tied to SDA, 11 tied to SCL), giving 0x40 to 0x47. Only an address byte that matches is acknowledged. A byte that does not match leaves SDA released until the next START.
- R2: The select inputs are captured at each START, so a change between transactions takes effect at the next transaction.
- R3: In a write transaction the first byte after the address loads the pointer. A transaction that ends after the pointer byte changes nothing but the pointer and produces no write strobe.
- R4: Reads use the last pointer written. The pointer is kept across any number of reads, and it is 0x00 after reset.
- R5: Data words are sent upper byte first, and each byte most significant bit first. Every completed pair of data bytes in a write is acknowledged and pulses `wrStrobe` for one cycle with `wrPtr` and `wrData`. Only pointer 0x02 changes the configuration word. A word written to any other pointer is discarded.
- R6: Reading a word returns `objVal` at pointer 0x00, `{ambVal, 2'b00}` at 0x01, the configuration word at 0x02, 0x5449 at 0xFE, 0x0067 at 0xFF and 0x0000 anywhere else. Each word fetched for transmission gives a one-cycle `rdStrobe`.
- R7: When the master answers a read byte with a NACK, the block releases SDA and drives nothing more until the next START.
- R8: A first byte of the form 0000_1xxx after START gets no acknowledge and sets `hsMode`. `hsMode` stays set through repeated STARTs and clears only at STOP.
- R9: A STOP or repeated START at any point returns the block to address reception and releases SDA. A word missing its second byte is never written.
- R10: The block only begins pulling SDA low while SCL is low.
- R11: The configuration word resets to 0x7400. Only bits 14 to 8 can be written, and all other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL bus level |
| sdaIn | input | 1 | Raw SDA bus level |
| adrSel1 | input | 1 | Address select bit (plain level) |
| adrSel0Code | input | 2 | Resolved four-state address select code |
| objVal | input | 16 | Live value read at pointer 0x00 |
| ambVal | input | 14 | Live ambient temperature read at pointer 0x01 |
| sdaPullDown | output | 1 | 1 pulls SDA low; 0 releases it |
| hsMode | output | 1 | High-speed filter mode, set by master code until STOP |
| wrStrobe | output | 1 | One-cycle pulse per completed word write |
| wrPtr | output | 8 | Pointer of the completed word write |
| wrData | output | 16 | Data of the completed word write |
| rdStrobe | output | 1 | One-cycle pulse per word fetched for a read |
| cfgWord | output | 16 | Current configuration word |

## Verification
Each bus line passes through two synchronizer flops and one edge-compare stage, and the response is registered once more. A response to an SCL edge therefore appears three to four clocks after the edge. That covers an acknowledge, a new data bit, or a release. The bench master holds every bus phase for five clocks and samples SDA one full phase after SCL rises, which is well past that latency. The strobes, the configuration word and `hsMode` are checked only once the transaction has closed with STOP, when all of them have settled.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int AMB_W  = 14;
  localparam int CNT_W  = 4;

  localparam logic [BYTE_W-1:0] PTR_OBJ = 8'h00;
  localparam logic [BYTE_W-1:0] PTR_AMB = 8'h01;
  localparam logic [BYTE_W-1:0] PTR_CFG = 8'h02;
  localparam logic [BYTE_W-1:0] PTR_MFR = 8'hFE;
  localparam logic [BYTE_W-1:0] PTR_DEV = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_PTR, S_WDATA, S_READ, S_SKIP
  } twsState_t;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic latchAdr;
    logic shiftIn;
    logic loadPtr;
    logic takeMsb;
    logic commitWord;
    logic loadRead;
    logic shiftOut;
  } dpStrobe_t;
endpackage

// File: rtl/tws_ctrl.sv
`timescale 1ns/1ps
module tws_ctrl
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              addrMatch,
  input  logic              hsCode,
  input  logic              txBit,
  output dpStrobe_t         stb,
  output logic              sdaBit,
  output logic              sdaPullDown,
  output logic              hsMode,
  output logic              sclLvl,
  output logic              stopEv
);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow, sclRise, sclFall, startEv;
  twsState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic ackOn, txOn, rdLsb, wrLsb, nackSeen;
  logic counting, byteDone, slotEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow  = sclSync[1];
  assign sdaNow  = sdaSync[1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign sclLvl  = sclNow;
  assign sdaBit  = sdaNow;

  assign counting = (state != S_IDLE) && (state != S_SKIP);
  assign byteDone = sclFall && counting && (bitCnt == ACK_SLOT);
  assign slotEnd  = sclFall && counting && (bitCnt == ACK_DONE);

  always_comb begin
    stb            = '0;
    stb.latchAdr   = startEv;
    stb.shiftIn    = sclRise && (bitCnt < ACK_SLOT) &&
                     (state == S_ADDR || state == S_PTR || state == S_WDATA);
    stb.loadPtr    = byteDone && (state == S_PTR);
    stb.takeMsb    = byteDone && (state == S_WDATA) && !wrLsb;
    stb.commitWord = byteDone && (state == S_WDATA) && wrLsb;
    stb.loadRead   = slotEnd && ((state == S_ADDR && addrMatch && rxByte[0]) ||
                                 (state == S_READ && !nackSeen && rdLsb));
    stb.shiftOut   = sclFall && (state == S_READ) &&
                     (((bitCnt >= 4'd1) && (bitCnt < ACK_SLOT)) ||
                      ((bitCnt == ACK_DONE) && !nackSeen && !rdLsb));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      ackOn    <= 1'b0;
      txOn     <= 1'b0;
      rdLsb    <= 1'b0;
      wrLsb    <= 1'b0;
      nackSeen <= 1'b0;
      hsMode   <= 1'b0;
    end else if (stopEv) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
      txOn   <= 1'b0;
      hsMode <= 1'b0;
    end else if (startEv) begin
      state  <= S_ADDR;
      bitCnt <= '0;
      ackOn  <= 1'b0;
      txOn   <= 1'b0;
      rdLsb  <= 1'b0;
      wrLsb  <= 1'b0;
    end else if (sclRise && counting) begin
      if (bitCnt < ACK_SLOT) bitCnt <= bitCnt + 1'b1;
      else if (bitCnt == ACK_SLOT) begin
        bitCnt   <= ACK_DONE;
        nackSeen <= sdaNow;
      end
    end else if (byteDone) begin
      unique case (state)
        S_ADDR: begin
          if (addrMatch) ackOn <= 1'b1;
          else begin
            state <= S_SKIP;
            if (hsCode) hsMode <= 1'b1;
          end
        end
        S_PTR:   ackOn <= 1'b1;
        S_WDATA: begin
          ackOn <= 1'b1;
          wrLsb <= ~wrLsb;
        end
        S_READ:  txOn <= 1'b0;
        default: ;
      endcase
    end else if (slotEnd) begin
      ackOn  <= 1'b0;
      bitCnt <= '0;
      unique case (state)
        S_ADDR: begin
          state <= rxByte[0] ? S_READ : S_PTR;
          txOn  <= rxByte[0];
          rdLsb <= 1'b0;
        end
        S_PTR:  state <= S_WDATA;
        S_READ: begin
          if (nackSeen) state <= S_SKIP;
          else begin
            txOn  <= 1'b1;
            rdLsb <= ~rdLsb;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullDown = ackOn | (txOn & ~txBit);
endmodule

// File: rtl/tws_dpath.sv
`timescale 1ns/1ps
module tws_dpath
  import tws_pkg::*;
#(
  parameter logic [3:0]        ADDR_HI   = 4'b1000,
  parameter logic [WORD_W-1:0] MFR_ID    = 16'h5449,
  parameter logic [WORD_W-1:0] DEV_ID    = 16'h0067,
  parameter logic [WORD_W-1:0] CFG_RESET = 16'h7400,
  parameter logic [WORD_W-1:0] CFG_WMASK = 16'h7F00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  input  logic              adrSel1,
  input  logic [1:0]        adrSel0Code,
  input  logic [WORD_W-1:0] objVal,
  input  logic [AMB_W-1:0]  ambVal,
  output logic [BYTE_W-1:0] rxByte,
  output logic              addrMatch,
  output logic              hsCode,
  output logic              txBit,
  output logic              wrStrobe,
  output logic [BYTE_W-1:0] wrPtr,
  output logic [WORD_W-1:0] wrData,
  output logic              rdStrobe,
  output logic [WORD_W-1:0] cfgWord
);
  localparam int AMB_PAD = WORD_W - AMB_W;

  logic [2:0]        adrLatch;
  logic [BYTE_W-1:0] ptrReg, msbHold;
  logic [WORD_W-1:0] txShift, rdWord, newWord;

  assign newWord   = {msbHold, rxByte};
  assign addrMatch = (rxByte[BYTE_W-1:1] == {ADDR_HI, adrLatch});
  assign hsCode    = (rxByte[BYTE_W-1:3] == 5'b00001);
  assign txBit     = txShift[WORD_W-1];

  always_comb begin
    case (ptrReg)
      PTR_OBJ: rdWord = objVal;
      PTR_AMB: rdWord = {ambVal, {AMB_PAD{1'b0}}};
      PTR_CFG: rdWord = cfgWord;
      PTR_MFR: rdWord = MFR_ID;
      PTR_DEV: rdWord = DEV_ID;
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adrLatch <= '0;
      rxByte   <= '0;
      ptrReg   <= '0;
      msbHold  <= '0;
      txShift  <= '1;
      cfgWord  <= CFG_RESET & CFG_WMASK;
      wrStrobe <= 1'b0;
      wrPtr    <= '0;
      wrData   <= '0;
      rdStrobe <= 1'b0;
    end else begin
      wrStrobe <= stb.commitWord;
      rdStrobe <= stb.loadRead;
      if (stb.latchAdr) adrLatch <= {adrSel1, adrSel0Code};
      if (stb.shiftIn)  rxByte   <= {rxByte[BYTE_W-2:0], sdaBit};
      if (stb.loadPtr)  ptrReg   <= rxByte;
      if (stb.takeMsb)  msbHold  <= rxByte;
      if (stb.commitWord) begin
        wrPtr  <= ptrReg;
        wrData <= newWord;
        if (ptrReg == PTR_CFG) cfgWord <= newWord & CFG_WMASK;
      end
      if (stb.loadRead)      txShift <= rdWord;
      else if (stb.shiftOut) txShift <= {txShift[WORD_W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/tws_sensor_slave.sv
`timescale 1ns/1ps
module tws_sensor_slave
  import tws_pkg::*;
#(
  parameter logic [3:0]  ADDR_HI   = 4'b1000,
  parameter logic [15:0] MFR_ID    = 16'h5449,
  parameter logic [15:0] DEV_ID    = 16'h0067,
  parameter logic [15:0] CFG_RESET = 16'h7400,
  parameter logic [15:0] CFG_WMASK = 16'h7F00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        adrSel1,
  input  logic [1:0]  adrSel0Code,
  input  logic [15:0] objVal,
  input  logic [13:0] ambVal,
  output logic        sdaPullDown,
  output logic        hsMode,
  output logic        wrStrobe,
  output logic [7:0]  wrPtr,
  output logic [15:0] wrData,
  output logic        rdStrobe,
  output logic [15:0] cfgWord
);
  dpStrobe_t         stb;
  logic [BYTE_W-1:0] rxByte;
  logic addrMatch, hsCode, txBit, sdaBit, sclLvl, stopEv;

  tws_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .addrMatch(addrMatch), .hsCode(hsCode), .txBit(txBit),
    .stb(stb), .sdaBit(sdaBit), .sdaPullDown(sdaPullDown), .hsMode(hsMode),
    .sclLvl(sclLvl), .stopEv(stopEv)
  );

  tws_dpath #(
    .ADDR_HI(ADDR_HI), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
    .CFG_RESET(CFG_RESET), .CFG_WMASK(CFG_WMASK)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit),
    .adrSel1(adrSel1), .adrSel0Code(adrSel0Code),
    .objVal(objVal), .ambVal(ambVal),
    .rxByte(rxByte), .addrMatch(addrMatch), .hsCode(hsCode), .txBit(txBit),
    .wrStrobe(wrStrobe), .wrPtr(wrPtr), .wrData(wrData),
    .rdStrobe(rdStrobe), .cfgWord(cfgWord)
  );
endmodule

// File: rtl/tws_sensor_slave_chk.sv
`timescale 1ns/1ps
module tws_sensor_slave_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sclLvl,
  input logic        stopEv,
  input logic        sdaPullDown,
  input logic        hsMode,
  input logic        wrStrobe,
  input logic [7:0]  wrPtr,
  input logic        rdStrobe,
  input logic [15:0] cfgWord
);
  AST_PD_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> !sclLvl); // R10

  AST_HS_CLEARS_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsMode) |-> $past(stopEv)); // R8

  AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord != $past(cfgWord)) |-> (wrStrobe && wrPtr == 8'h02)); // R5

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R5

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !rdStrobe); // R6

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopEv) |-> !sdaPullDown); // R9
endmodule

bind tws_sensor_slave tws_sensor_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .stopEv(stopEv),
  .sdaPullDown(sdaPullDown), .hsMode(hsMode), .wrStrobe(wrStrobe),
  .wrPtr(wrPtr), .rdStrobe(rdStrobe), .cfgWord(cfgWord)
);

// File: tb/tws_sensor_slave_tb_top.sv
`timescale 1ns/1ps
module tws_sensor_slave_tb_top;
  localparam int QTR = 5;
  localparam logic [15:0] OBJ_V = 16'hA5C3;
  localparam logic [13:0] AMB_V = 14'h0320;
  localparam logic [23:0] RD_TBL [6] = '{
    {8'h00, 16'hA5C3}, {8'h01, 16'h0C80}, {8'h02, 16'h7400},
    {8'hFE, 16'h5449}, {8'hFF, 16'h0067}, {8'h7B, 16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic adrSel1 = 1'b0;
  logic [1:0] adrSel0Code = 2'b00;
  logic sdaPullDown, hsMode, wrStrobe, rdStrobe;
  logic [7:0] wrPtr;
  logic [15:0] wrData, cfgWord;
  logic sdaBus;

  int nChecks = 0, nFails = 0, wrCount = 0, rdCount = 0, badRise = 0, cyc = 0;
  logic [7:0]  lastWrPtr = '0;
  logic [15:0] lastWrData = '0;
  logic prevPd = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sdaBus = mSda & ~sdaPullDown;

  tws_sensor_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .adrSel1(adrSel1), .adrSel0Code(adrSel0Code),
    .objVal(OBJ_V), .ambVal(AMB_V),
    .sdaPullDown(sdaPullDown), .hsMode(hsMode), .wrStrobe(wrStrobe),
    .wrPtr(wrPtr), .wrData(wrData), .rdStrobe(rdStrobe), .cfgWord(cfgWord)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (wrStrobe) begin
        wrCount++;
        lastWrPtr  = wrPtr;
        lastWrData = wrData;
      end
      if (rdStrobe) rdCount++;
      if (sdaPullDown && !prevPd && scl) badRise++;
    end
    prevPd = sdaPullDown;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); scl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); scl = 1'b1; waitQ(); mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ(); scl = 1'b1; waitQ(); acked = ~sdaBus; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic lastOne, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); scl = 1'b1; waitQ(); b[i] = sdaBus; waitQ(); scl = 1'b0; waitQ();
    end
    mSda = lastOne; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0; waitQ(); mSda = 1'b1;
  endtask

  task automatic setPtr(input logic [6:0] a, input logic [7:0] p, output logic ok);
    logic k1, k2;
    busStart(); sendByte({a, 1'b0}, k1); sendByte(p, k2); busStop();
    ok = k1 & k2;
  endtask

  task automatic writeWord(input logic [6:0] a, input logic [7:0] p, input logic [15:0] d, output logic ok);
    logic k1, k2, k3, k4;
    busStart(); sendByte({a, 1'b0}, k1); sendByte(p, k2);
    sendByte(d[15:8], k3); sendByte(d[7:0], k4); busStop();
    ok = k1 & k2 & k3 & k4;
  endtask

  task automatic readWord(input logic [6:0] a, output logic [15:0] d, output logic ok);
    logic k1;
    logic [7:0] hi, lo;
    busStart(); sendByte({a, 1'b1}, k1);
    recvByte(1'b0, hi); recvByte(1'b1, lo); busStop();
    d = {hi, lo};
    ok = k1;
  endtask

  initial begin
    logic ok, ack;
    logic [15:0] rd;
    logic [7:0] b;
    int wc, rc;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check(cfgWord == 16'h7400, "R11 reset config", cfgWord, 16'h7400);
    check(sdaPullDown == 1'b0, "R10 idle released", sdaPullDown, 0);
    check(hsMode == 1'b0, "R8 reset hsMode", hsMode, 0);

    // R4: pointer is 0x00 after reset
    rc = rdCount;
    readWord(7'h40, rd, ok);
    check(ok && rd == OBJ_V, "R4 reset pointer read", rd, OBJ_V);
    check(rdCount == rc + 1, "R6 one rdStrobe per word", rdCount - rc, 1);

    // table walk: R6 read map, R4 retained pointer
    for (int i = 0; i < 6; i++) begin
      setPtr(7'h40, RD_TBL[i][23:16], ok);
      check(ok, "R3 pointer write acked", ok, 1);
      readWord(7'h40, rd, ok);
      check(ok && rd == RD_TBL[i][15:0], "R6 register read", rd, RD_TBL[i][15:0]);
      readWord(7'h40, rd, ok);
      check(rd == RD_TBL[i][15:0], "R4 pointer kept on reread", rd, RD_TBL[i][15:0]);
    end

    // R5/R11: configuration write
    wc = wrCount;
    writeWord(7'h40, 8'h02, 16'hFFFF, ok);
    check(ok, "R5 word write acked", ok, 1);
    check(wrCount == wc + 1, "R5 one wrStrobe", wrCount - wc, 1);
    check(lastWrPtr == 8'h02 && lastWrData == 16'hFFFF, "R5 strobe ptr/data",
          {lastWrPtr, lastWrData}, {8'h02, 16'hFFFF});
    check(cfgWord == 16'h7F00, "R11 writable mask", cfgWord, 16'h7F00);
    readWord(7'h40, rd, ok);
    check(rd == 16'h7F00, "R11 config readback", rd, 16'h7F00);
    writeWord(7'h40, 8'h02, 16'h8A5F, ok);
    check(cfgWord == 16'h0A00, "R11 second pattern", cfgWord, 16'h0A00);
    writeWord(7'h40, 8'h02, 16'hFFFF, ok);

    // R5: write to read-only pointer is discarded
    wc = wrCount;
    writeWord(7'h40, 8'h01, 16'h1234, ok);
    check(ok && wrCount == wc + 1, "R5 read-only write acked", wrCount - wc, 1);
    check(cfgWord == 16'h7F00, "R5 config untouched", cfgWord, 16'h7F00);
    readWord(7'h40, rd, ok);
    check(rd == 16'h0C80, "R5 read-only value kept", rd, 16'h0C80);

    // R3: pointer-only transaction
    wc = wrCount;
    setPtr(7'h40, 8'h02, ok);
    check(wrCount == wc, "R3 no strobe on pointer-only", wrCount - wc, 0);
    readWord(7'h40, rd, ok);
    check(rd == 16'h7F00, "R3 pointer moved only", rd, 16'h7F00);

    // R1: address decode
    busStart(); sendByte({7'h48, 1'b0}, ack); busStop();
    check(!ack, "R1 foreign address ignored", ack, 0);
    busStart(); sendByte({7'h41, 1'b0}, ack); busStop();
    check(!ack, "R1 neighbour address ignored", ack, 0);

    // R1/R2: select inputs resampled per transaction
    adrSel1 = 1'b1; adrSel0Code = 2'b11;
    readWord(7'h47, rd, ok);
    check(ok && rd == 16'h7F00, "R1 code 11 gives 0x47", {15'd0, ok}, 1);
    busStart(); sendByte({7'h40, 1'b0}, ack); busStop();
    check(!ack, "R2 old address dropped", ack, 0);
    adrSel1 = 1'b0; adrSel0Code = 2'b10;
    busStart(); sendByte({7'h42, 1'b0}, ack); busStop();
    check(ack, "R2 new address 0x42 taken", ack, 1);
    adrSel0Code = 2'b00;

    // R8: high-speed master code
    busStart(); sendByte(8'h08, ack);
    check(!ack, "R8 master code not acked", ack, 0);
    check(hsMode, "R8 hsMode set", hsMode, 1);
    busStart(); sendByte({7'h40, 1'b0}, ack);
    check(ack && hsMode, "R8 kept over repeated start", {ack, hsMode}, 2'b11);
    sendByte(8'h02, ack); busStop();
    check(!hsMode, "R8 cleared by stop", hsMode, 0);

    // R9: partial word by STOP
    wc = wrCount;
    busStart(); sendByte({7'h40, 1'b0}, ack); sendByte(8'h02, ack); sendByte(8'h00, ack); busStop();
    check(wrCount == wc && cfgWord == 16'h7F00, "R9 partial word dropped at stop", cfgWord, 16'h7F00);
    // R9: partial word by repeated START, then read
    busStart(); sendByte({7'h40, 1'b0}, ack); sendByte(8'h02, ack); sendByte(8'h00, ack);
    busStart(); sendByte({7'h40, 1'b1}, ack);
    check(ack, "R9 address after repeated start", ack, 1);
    recvByte(1'b0, b); rd[15:8] = b;
    recvByte(1'b1, b); rd[7:0] = b;
    // R7: released after NACK
    waitQ();
    check(sdaPullDown == 1'b0, "R7 released after NACK", sdaPullDown, 0);
    busStop();
    check(rd == 16'h7F00 && wrCount == wc, "R9 no write after repeated start", rd, 16'h7F00);
    check(sdaPullDown == 1'b0, "R9 released after stop", sdaPullDown, 0);

    check(badRise == 0, "R10 pull-down rose with SCL high", badRise, 0);

    done = 1'b1;
    summary();
  end
endmodule